// File: doc/BRIEF.md
# Receive Mailbox Matching Engine

This engine chooses the receive mailbox that takes an arriving frame identifier. It holds a set of mailbox slots. Each slot carries an identifier, a 4-bit activity code and an acceptance mask of its own. When a frame arrives, the engine walks the slots one per clock, from index 0 upward. It compares the frame identifier with each active slot under that slot's effective mask. When the walk completes, it emits a one-cycle result: the winning slot, or a no-match flag.

Among the matching slots, the first one that is free (code EMPTY) stores the frame, and its code moves to FULL. If every matching slot is already occupied, the last matching slot in walk order is overwritten, its code moves to OVERRUN, and the result reports an overrun. Software may deactivate a slot in the middle of a walk. If that slot is the provisional winner, the winner is dropped and the walk simply carries on.

Each slot's mask can be taken from two sources, chosen by a mode select. In individual mode, every slot uses its own mask. Those masks have no reset value and can only be written in freeze mode. In shared mode, slots 14 and 15 each use a dedicated mask and all other slots use one common mask. A frame that arrives while a walk is running is held in a one-deep slot and is walked as soon as the current walk ends.

Top module: `rx_mailbox_matcher`

## Requirements
- R1: An identifier bit is compared only where the effective mask bit is 1. Where the mask bit is 0, that identifier bit never affects whether a slot matches.
- R2: Slots are walked in ascending index order. The lowest-index matching slot whose code is EMPTY (4'b0100) wins. The result reports its index with no overrun, and its code becomes FULL (4'b0010).
- R3: A matching slot whose code is not EMPTY is passed over when a later matching EMPTY slot exists. The later slot wins.
- R4: When slots match but none is EMPTY, the highest-index matching slot wins. The result flags an overrun, and the slot's code becomes OVERRUN (4'b0110).
- R5: Writing code INACTIVE (4'b0000) to the provisional winner during a walk discards that winner. The walk continues to the end, and only the slots after the discarded winner can still win.
- R6: With `indivMaskMode`=1, each slot uses its own mask. With `indivMaskMode`=0, the masks are shared:
  - slot 14 uses the mask written with `sharedWrSel`=1;
  - slot 15 uses the mask written with `sharedWrSel`=2;
  - every other slot uses the mask written with `sharedWrSel`=0.
- R7: An individual-mask write is accepted only while `freezeMode`=1. Outside freeze mode the write leaves the stored mask unchanged.
- R8: A frame that matches no active slot gives a result with `doneNoMatch`=1 and `doneOverrun`=0.
- R9: A slot whose code is INACTIVE never matches.
- R10: `doneValid` is high for exactly one cycle. It rises NUM_SLOTS clock edges after the edge that samples `frameValid` on an idle engine.
- R11: A `frameValid` strobe that arrives during a walk is held. Its walk starts after the current one ends, and both results are delivered in arrival order.
- R12: After reset, `doneValid` is 0, every slot code is INACTIVE and the shared masks are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameValid | input | 1 | Frame-arrival strobe |
| frameId | input | ID_W | Identifier of the arriving frame |
| indivMaskMode | input | 1 | 1: per-slot masks, 0: shared masks |
| freezeMode | input | 1 | Enables individual-mask writes |
| slotWrEn | input | 1 | Slot identifier and code write strobe |
| slotWrIdx | input | IDX_W | Slot to write |
| slotWrId | input | ID_W | Identifier value to write |
| slotWrCode | input | 4 | Code value to write |
| maskWrEn | input | 1 | Individual-mask write strobe |
| maskWrIdx | input | IDX_W | Slot whose mask is written |
| maskWrVal | input | ID_W | Mask value to write |
| sharedWrEn | input | 1 | Shared-mask write strobe |
| sharedWrSel | input | 2 | 0 common, 1 slot-14 mask, 2 slot-15 mask |
| sharedWrVal | input | ID_W | Shared mask value to write |
| doneValid | output | 1 | One-cycle result strobe |
| doneIdx | output | IDX_W | Winning slot index |
| doneOverrun | output | 1 | Winner was overwritten (no free match) |
| doneNoMatch | output | 1 | No active slot matched |

## Verification
Some properties are checked by assertions on every cycle:
- the walk index advances by one per cycle;
- a strobe arriving during a walk is held;
- the result strobe is one cycle wide, and a no-match result never also reports an overrun;
- a stored winner ends with code FULL and an overwritten winner ends with code OVERRUN;
- an inactive slot never becomes the winner;
- a mask write outside freeze mode leaves the mask unchanged.

Other properties need whole frame sequences, so only the bench scenarios can show them:
- which slot wins over every free/occupied pattern of four duplicate slots;
- don't-care behaviour for each identifier bit;
- the shared-mask routing to slots 14 and 15;
- the outcome of deactivating the winner mid-walk;
- the ordering of a held frame.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;
  localparam logic [3:0] CODE_INACTIVE = 4'b0000;
  localparam logic [3:0] CODE_EMPTY    = 4'b0100;
  localparam logic [3:0] CODE_FULL     = 4'b0010;
  localparam logic [3:0] CODE_OVERRUN  = 4'b0110;

  localparam int DEDICATED_SLOT_A = 14;
  localparam int DEDICATED_SLOT_B = 15;

  typedef struct packed {
    logic start;
    logic scanEn;
    logic finish;
  } scanCtl_t;
endpackage

// File: rtl/rxmb_ctrl.sv
module rxmb_ctrl
  import rxmb_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int ID_W      = 11,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameValid,
  input  logic [ID_W-1:0]  frameId,
  output scanCtl_t         ctl,
  output logic [IDX_W-1:0] scanIdx,
  output logic [ID_W-1:0]  startId
);
  logic            busy;
  logic            pendValid;
  logic [ID_W-1:0] pendId;
  logic            startNow;
  logic            lastSlot;

  assign startNow   = !busy && (frameValid || pendValid);
  assign startId    = pendValid ? pendId : frameId;
  assign lastSlot   = scanIdx == IDX_W'(NUM_SLOTS - 1);
  assign ctl.start  = startNow;
  assign ctl.scanEn = busy;
  assign ctl.finish = busy && lastSlot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      scanIdx <= '0;
    end else if (startNow) begin
      busy    <= 1'b1;
      scanIdx <= '0;
    end else if (busy) begin
      if (lastSlot) busy <= 1'b0;
      else          scanIdx <= scanIdx + 1'b1;
    end
  end

  // one-deep hold for a frame arriving during a walk
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendId    <= '0;
    end else if (startNow && pendValid) begin
      pendValid <= frameValid;
      pendId    <= frameId;
    end else if (busy && frameValid) begin
      pendValid <= 1'b1;
      pendId    <= frameId;
    end
  end

  a_r10_scan_advances: assert property (@(posedge clk) disable iff (!rstN)
    busy && !lastSlot |=> busy && scanIdx == $past(scanIdx) + 1'b1);

  a_r11_strobe_held: assert property (@(posedge clk) disable iff (!rstN)
    busy && frameValid |=> pendValid && pendId == $past(frameId));

  a_r11_held_starts: assert property (@(posedge clk) disable iff (!rstN)
    pendValid && !busy |=> busy && scanIdx == '0);
endmodule

// File: rtl/rxmb_datapath.sv
module rxmb_datapath
  import rxmb_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int ID_W      = 11,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  scanCtl_t         ctl,
  input  logic [IDX_W-1:0] scanIdx,
  input  logic [ID_W-1:0]  startId,
  input  logic             indivMaskMode,
  input  logic             freezeMode,
  input  logic             slotWrEn,
  input  logic [IDX_W-1:0] slotWrIdx,
  input  logic [ID_W-1:0]  slotWrId,
  input  logic [3:0]       slotWrCode,
  input  logic             maskWrEn,
  input  logic [IDX_W-1:0] maskWrIdx,
  input  logic [ID_W-1:0]  maskWrVal,
  input  logic             sharedWrEn,
  input  logic [1:0]       sharedWrSel,
  input  logic [ID_W-1:0]  sharedWrVal,
  output logic             doneValid,
  output logic [IDX_W-1:0] doneIdx,
  output logic             doneOverrun,
  output logic             doneNoMatch
);
  logic [ID_W-1:0] slotId    [NUM_SLOTS];
  logic [3:0]      slotCode  [NUM_SLOTS];
  logic [ID_W-1:0] indivMask [NUM_SLOTS];
  logic [ID_W-1:0] legacyMask[NUM_SLOTS];
  logic [ID_W-1:0] effMask   [NUM_SLOTS];
  logic [ID_W-1:0] commonMask, dedMaskA, dedMaskB;
  logic [ID_W-1:0] curId;

  logic             winValid, winFree;
  logic [IDX_W-1:0] winIdx;
  logic             nextValid, nextFree;
  logic [IDX_W-1:0] nextIdx;
  logic             idMatch, slotHit, killWin, killCur;
  logic [3:0]       curCode;

  // mask routing per slot
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_mask
    if (g == DEDICATED_SLOT_A) begin : g_a
      assign legacyMask[g] = dedMaskA;
    end else if (g == DEDICATED_SLOT_B) begin : g_b
      assign legacyMask[g] = dedMaskB;
    end else begin : g_c
      assign legacyMask[g] = commonMask;
    end
    assign effMask[g] = indivMaskMode ? indivMask[g] : legacyMask[g];
  end

  // per-slot masks: no reset, freeze-gated writes
  always_ff @(posedge clk) begin
    if (maskWrEn && freezeMode) indivMask[maskWrIdx] <= maskWrVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commonMask <= '1;
      dedMaskA   <= '1;
      dedMaskB   <= '1;
    end else if (sharedWrEn) begin
      case (sharedWrSel)
        2'd0:    commonMask <= sharedWrVal;
        2'd1:    dedMaskA   <= sharedWrVal;
        2'd2:    dedMaskB   <= sharedWrVal;
        default: ;
      endcase
    end
  end

  // compare of the slot under the walk pointer
  assign curCode = slotCode[scanIdx];
  assign idMatch = ((slotId[scanIdx] ^ curId) & effMask[scanIdx]) == '0;
  assign killCur = slotWrEn && slotWrCode == CODE_INACTIVE && slotWrIdx == scanIdx;
  assign slotHit = ctl.scanEn && idMatch && curCode != CODE_INACTIVE && !killCur;
  assign killWin = slotWrEn && slotWrCode == CODE_INACTIVE && winValid && slotWrIdx == winIdx;

  always_comb begin
    nextValid = winValid && !killWin;
    nextFree  = winFree && !killWin;
    nextIdx   = winIdx;
    if (slotHit && !nextFree) begin
      nextValid = 1'b1;
      nextFree  = curCode == CODE_EMPTY;
      nextIdx   = scanIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curId    <= '0;
      winValid <= 1'b0;
      winFree  <= 1'b0;
      winIdx   <= '0;
    end else if (ctl.start) begin
      curId    <= startId;
      winValid <= 1'b0;
      winFree  <= 1'b0;
      winIdx   <= '0;
    end else if (ctl.scanEn) begin
      winValid <= nextValid;
      winFree  <= nextFree;
      winIdx   <= nextIdx;
    end
  end

  // slot table: commit at walk end, configuration write takes precedence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        slotId[i]   <= '0;
        slotCode[i] <= CODE_INACTIVE;
      end
    end else begin
      if (ctl.finish && nextValid)
        slotCode[nextIdx] <= nextFree ? CODE_FULL : CODE_OVERRUN;
      if (slotWrEn) begin
        slotId[slotWrIdx]   <= slotWrId;
        slotCode[slotWrIdx] <= slotWrCode;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneValid   <= 1'b0;
      doneIdx     <= '0;
      doneOverrun <= 1'b0;
      doneNoMatch <= 1'b0;
    end else begin
      doneValid <= ctl.finish;
      if (ctl.finish) begin
        doneIdx     <= nextIdx;
        doneOverrun <= nextValid && !nextFree;
        doneNoMatch <= !nextValid;
      end
    end
  end

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  a_r8_nomatch_clean: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneNoMatch |-> !doneOverrun);

  a_r2_store_full: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && !doneNoMatch && !doneOverrun && !$past(slotWrEn)
      |-> slotCode[doneIdx] == CODE_FULL);

  a_r4_store_overrun: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneOverrun && !$past(slotWrEn)
      |-> slotCode[doneIdx] == CODE_OVERRUN);

  a_r9_inactive_never_wins: assert property (@(posedge clk) disable iff (!rstN)
    ctl.scanEn && curCode == CODE_INACTIVE
      |=> !(winValid && winIdx == $past(scanIdx)));

  a_r7_mask_locked: assert property (@(posedge clk) disable iff (!rstN)
    maskWrEn && !freezeMode
      |=> indivMask[$past(maskWrIdx)] == $past(indivMask[maskWrIdx]));
endmodule

// File: rtl/rx_mailbox_matcher.sv
module rx_mailbox_matcher
  import rxmb_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int ID_W      = 11,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameValid,
  input  logic [ID_W-1:0]  frameId,
  input  logic             indivMaskMode,
  input  logic             freezeMode,
  input  logic             slotWrEn,
  input  logic [IDX_W-1:0] slotWrIdx,
  input  logic [ID_W-1:0]  slotWrId,
  input  logic [3:0]       slotWrCode,
  input  logic             maskWrEn,
  input  logic [IDX_W-1:0] maskWrIdx,
  input  logic [ID_W-1:0]  maskWrVal,
  input  logic             sharedWrEn,
  input  logic [1:0]       sharedWrSel,
  input  logic [ID_W-1:0]  sharedWrVal,
  output logic             doneValid,
  output logic [IDX_W-1:0] doneIdx,
  output logic             doneOverrun,
  output logic             doneNoMatch
);
  scanCtl_t         ctl;
  logic [IDX_W-1:0] scanIdx;
  logic [ID_W-1:0]  startId;

  rxmb_ctrl #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameId(frameId),
    .ctl(ctl), .scanIdx(scanIdx), .startId(startId)
  );

  rxmb_datapath #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .scanIdx(scanIdx), .startId(startId),
    .indivMaskMode(indivMaskMode), .freezeMode(freezeMode),
    .slotWrEn(slotWrEn), .slotWrIdx(slotWrIdx), .slotWrId(slotWrId), .slotWrCode(slotWrCode),
    .maskWrEn(maskWrEn), .maskWrIdx(maskWrIdx), .maskWrVal(maskWrVal),
    .sharedWrEn(sharedWrEn), .sharedWrSel(sharedWrSel), .sharedWrVal(sharedWrVal),
    .doneValid(doneValid), .doneIdx(doneIdx), .doneOverrun(doneOverrun),
    .doneNoMatch(doneNoMatch)
  );
endmodule

// File: tb/rx_mailbox_matcher_test.sv
module rx_mailbox_matcher_test;
  localparam int NS = 16;
  localparam int IW = 11;
  localparam int XW = 4;
  localparam logic [3:0] C_INACT = 4'b0000, C_EMPTY = 4'b0100,
                         C_FULL = 4'b0010, C_OVR = 4'b0110;

  logic clk = 1'b0, rstN = 1'b0;
  logic frameValid = 0, indivMaskMode = 0, freezeMode = 0;
  logic slotWrEn = 0, maskWrEn = 0, sharedWrEn = 0;
  logic [IW-1:0] frameId = '0, slotWrId = '0, maskWrVal = '0, sharedWrVal = '0;
  logic [XW-1:0] slotWrIdx = '0, maskWrIdx = '0, doneIdx;
  logic [3:0] slotWrCode = '0;
  logic [1:0] sharedWrSel = '0;
  logic doneValid, doneOverrun, doneNoMatch;

  int nChecks = 0, nFails = 0;
  int gotRes, gotLat;

  rx_mailbox_matcher #(.NUM_SLOTS(NS), .ID_W(IW)) uut (.*);

  always #10 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  // result encoding: -1 no match, idx, idx+100 for overrun
  function automatic int enc(input bit nm, input int idx, input bit ov);
    return nm ? -1 : idx + (ov ? 100 : 0);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeSlot(input int idx, input int id, input logic [3:0] code);
    slotWrEn = 1; slotWrIdx = XW'(idx); slotWrId = IW'(id); slotWrCode = code;
    @(negedge clk); slotWrEn = 0;
  endtask

  task automatic writeMask(input int idx, input int m);
    maskWrEn = 1; maskWrIdx = XW'(idx); maskWrVal = IW'(m);
    @(negedge clk); maskWrEn = 0;
  endtask

  task automatic writeShared(input int sel, input int m);
    sharedWrEn = 1; sharedWrSel = 2'(sel); sharedWrVal = IW'(m);
    @(negedge clk); sharedWrEn = 0;
  endtask

  task automatic clearSlots();
    for (int i = 0; i < NS; i++) writeSlot(i, 0, C_INACT);
  endtask

  // strobe a frame; optionally deactivate killIdx when counter hits killAt
  task automatic runFrame(input int id, input int killAt, input int killIdx);
    int cnt;
    frameValid = 1; frameId = IW'(id);
    @(negedge clk); frameValid = 0; cnt = 1;
    while (!doneValid && cnt < 60) begin
      if (killAt != 0 && cnt == killAt) begin
        slotWrEn = 1; slotWrIdx = XW'(killIdx); slotWrId = '0; slotWrCode = C_INACT;
      end else slotWrEn = 0;
      @(negedge clk); cnt++;
    end
    slotWrEn = 0;
    gotLat = cnt - 1;
    gotRes = doneValid ? enc(doneNoMatch, int'(doneIdx), doneOverrun) : -999;
    @(negedge clk);
  endtask

  initial begin
    int exp;
    int pos[4] = '{2, 5, 9, 13};
    logic [3:0] mc[4];
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R12 reset state
    chk(doneValid == 0, "R12 doneValid after reset", doneValid, 0);
    runFrame(11'h3, 0, 0);
    chk(gotRes == -1, "R12 all slots inactive after reset", gotRes, -1);
    writeSlot(0, 11'h3, C_EMPTY);
    runFrame(11'h2, 0, 0);
    chk(gotRes == -1, "R12 shared masks all ones after reset", gotRes, -1);
    runFrame(11'h3, 0, 0);
    chk(gotRes == 0, "R12 exact hit with reset masks", gotRes, 0);
    chk(gotLat == NS, "R10 done latency", gotLat, NS);

    // per-slot masks all ones, freeze on
    freezeMode = 1;
    for (int i = 0; i < NS; i++) writeMask(i, 11'h7FF);
    indivMaskMode = 1;
    clearSlots();

    // R1 sweep per identifier bit
    for (int b = 0; b < IW; b++) begin
      writeSlot(5, 0, C_EMPTY);
      writeMask(5, 11'h7FF ^ (1 << b));
      runFrame(1 << b, 0, 0);
      chk(gotRes == 5, $sformatf("R1 bit %0d masked is don't-care", b), gotRes, 5);
      writeSlot(5, 0, C_EMPTY);
      writeMask(5, 11'h7FF);
      runFrame(1 << b, 0, 0);
      chk(gotRes == -1, $sformatf("R1 bit %0d unmasked is compared", b), gotRes, -1);
    end
    writeSlot(5, 0, C_INACT);

    // R2 R3 R4 sweep over free/occupied patterns of four duplicates
    for (int pat = 0; pat < 16; pat++) begin
      clearSlots();
      for (int j = 0; j < 4; j++) begin
        mc[j] = pat[j] ? C_EMPTY : C_FULL;
        writeSlot(pos[j], 11'h1A5, mc[j]);
      end
      for (int f = 0; f < 2; f++) begin
        int w;
        w = -1;
        for (int j = 0; j < 4; j++) if (w < 0 && mc[j] == C_EMPTY) w = j;
        if (w >= 0) begin exp = pos[w]; mc[w] = C_FULL; end
        else begin exp = pos[3] + 100; mc[3] = C_OVR; end
        runFrame(11'h1A5, 0, 0);
        chk(gotRes == exp, $sformatf("R2/R3/R4 pattern %0d frame %0d (R2 R3 R4)", pat, f),
            gotRes, exp);
      end
    end

    // R8 and R9: inactive duplicate never matches
    clearSlots();
    writeSlot(4, 11'h0F0, C_INACT);
    runFrame(11'h0F0, 0, 0);
    chk(gotRes == -1, "R9 inactive slot ignored", gotRes, -1);
    writeSlot(6, 11'h0F1, C_EMPTY);
    runFrame(11'h0F0, 0, 0);
    chk(gotRes == -1, "R8 no match reported", gotRes, -1);
    runFrame(11'h0F1, 0, 0);
    chk(gotRes == 6, "R8 unmatched frame left slot EMPTY", gotRes, 6);

    // R5 deactivation of the provisional winner
    clearSlots();
    writeSlot(2, 11'h2AA, C_EMPTY);
    runFrame(11'h2AA, 7, 2);
    chk(gotRes == -1, "R5 winner dropped, no later match", gotRes, -1);
    writeSlot(2, 11'h2AA, C_EMPTY);
    writeSlot(10, 11'h2AA, C_EMPTY);
    runFrame(11'h2AA, 7, 2);
    chk(gotRes == 10, "R5 later free slot wins after drop", gotRes, 10);
    clearSlots();
    writeSlot(4, 11'h2AA, C_EMPTY);
    writeSlot(8, 11'h2AA, C_FULL);
    runFrame(11'h2AA, 7, 4);
    chk(gotRes == 108, "R5 later occupied slot overrun after drop", gotRes, 108);

    // R7 mask write outside freeze ignored
    clearSlots();
    writeSlot(5, 0, C_EMPTY);
    freezeMode = 0;
    writeMask(5, 0);
    runFrame(1, 0, 0);
    chk(gotRes == -1, "R7 mask write ignored outside freeze", gotRes, -1);
    freezeMode = 1;
    writeMask(5, 0);
    runFrame(1, 0, 0);
    chk(gotRes == 5, "R7 mask write accepted in freeze", gotRes, 5);
    writeMask(5, 11'h7FF);

    // R6 shared mask routing
    clearSlots();
    indivMaskMode = 0;
    writeShared(0, 11'h7F0);
    writeShared(1, 11'h7FF);
    writeShared(2, 11'h000);
    writeSlot(3, 11'h120, C_EMPTY);
    writeSlot(14, 11'h120, C_EMPTY);
    writeSlot(15, 11'h555, C_EMPTY);
    runFrame(11'h123, 0, 0);
    chk(gotRes == 3, "R6 common mask on slot 3", gotRes, 3);
    runFrame(11'h120, 0, 0);
    chk(gotRes == 14, "R6 dedicated mask on slot 14", gotRes, 14);
    runFrame(11'h7AB, 0, 0);
    chk(gotRes == 15, "R6 dedicated mask on slot 15", gotRes, 15);
    writeSlot(3, 11'h120, C_EMPTY);
    writeSlot(15, 11'h555, C_EMPTY);
    indivMaskMode = 1;
    runFrame(11'h123, 0, 0);
    chk(gotRes == -1, "R6 individual masks replace shared", gotRes, -1);

    // R11 strobe during a walk is held
    clearSlots();
    writeSlot(1, 11'h0A1, C_EMPTY);
    writeSlot(7, 11'h0B7, C_EMPTY);
    begin
      int seen, r0, r1;
      seen = 0; r0 = -999; r1 = -999;
      frameValid = 1; frameId = 11'h0A1;
      @(negedge clk); frameValid = 0;
      repeat (3) @(negedge clk);
      frameValid = 1; frameId = 11'h0B7;
      @(negedge clk); frameValid = 0;
      for (int c = 0; c < 80; c++) begin
        if (doneValid) begin
          if (seen == 0) r0 = enc(doneNoMatch, int'(doneIdx), doneOverrun);
          else r1 = enc(doneNoMatch, int'(doneIdx), doneOverrun);
          seen++;
        end
        @(negedge clk);
      end
      chk(seen == 2, "R11 two results delivered", seen, 2);
      chk(r0 == 1, "R11 first frame result", r0, 1);
      chk(r1 == 7, "R11 held frame result", r1, 7);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule